// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns a set of raw interrupt lines into a register of pending requests. A trigger-mode register picks, line by line, how each line is captured. A level-sensitive line reports whatever its input currently shows. An edge-sensitive line records a request on a low-to-high transition and holds it until it is acknowledged. An acknowledge names one line by number. It retires an edge-latched request and leaves level-sensitive requests alone.

Each line is held by its own four-state machine. The state packs the stored last level (bit 0) and the request (bit 1):

- `LS_QUIET`: input last seen low, nothing pending.
- `LS_ARMED`: input last seen high, nothing pending.
- `LS_PEND_LOW`: input last seen low, request pending.
- `LS_PEND_HIGH`: input last seen high, request pending.

In level mode, every state goes to `LS_PEND_HIGH` when the input is high and to `LS_QUIET` when it is low. In edge mode the transitions are:

- From `LS_QUIET`: a high input goes to `LS_PEND_HIGH` (rising edge); otherwise the line stays.
- From `LS_ARMED`: a low input goes to `LS_QUIET`; otherwise the line stays.
- From `LS_PEND_LOW`: a high input goes to `LS_PEND_HIGH`, whether or not an acknowledge arrives. With a low input, an acknowledge goes to `LS_QUIET`; otherwise the line stays.
- From `LS_PEND_HIGH`: with a high input, an acknowledge goes to `LS_ARMED`; otherwise the line stays. With a low input, an acknowledge goes to `LS_QUIET`; otherwise the line goes to `LS_PEND_LOW`.

Lines are sampled on the block clock and are assumed synchronous to it. A priority resolver reads the request register, and bus logic drives the mode write port.

Top module: `irql_latch`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `req_o` is all zeros and `mode_rd` is all zeros (every line edge-sensitive, no line seen high).
- R2: On a clock where bit i of `mode_wr_be` is 1, mode bit i becomes `mode_wr_data[i] & LEVEL_CAPABLE[i]`; other mode bits keep their value. The new value shows on `mode_rd` after that edge. Mode bit 1 means level-sensitive and 0 means edge-sensitive.
- R3: For a line whose mode bit is 1, `req_o[i]` after a clock edge equals `irq_in[i]` sampled at that edge, both when it rises and when it falls.
- R4: For a line whose mode bit is 1, an acknowledge naming that line does not change `req_o[i]`.
- R5: For a line whose mode bit is 0, a sample with `irq_in[i]`=1 sets `req_o[i]` after the edge when the previous sample of that line was 0. A line held high during reset counts as a rise on its first sample.
- R6: For a line whose mode bit is 0, `req_o[i]` stays set when the input falls, and a held-high input does not set it again once it is cleared.
- R7: `ack_stb`=1 with `ack_line`=i clears `req_o[i]` of an edge-sensitive line after the edge, unless R8 applies. Other lines are unaffected.
- R8: If an acknowledge for an edge-sensitive line arrives in the same cycle as a new rising edge on that line, the request stays set.
- R9: Mode is taken from the register value in force at the sampling edge. A line switched from level to edge while its input is high keeps its request until acknowledged, and is not set again by the held level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Raw interrupt lines, synchronous to clk |
| mode_wr_be | input | NUM_LINES | Per-bit write enable for the trigger-mode register |
| mode_wr_data | input | NUM_LINES | Trigger-mode write data (1 = level, 0 = edge) |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_line | input | $clog2(NUM_LINES) | Number of the line being acknowledged |
| req_o | output | NUM_LINES | Latched request register |
| mode_rd | output | NUM_LINES | Trigger-mode register read value |

## Verification
Two events can land on the same line in one cycle: an acknowledge and a fresh rising edge. A mode write can also coincide with a level line being held high. Directed sequences pulse a line low and then raise it in the same cycle as its acknowledge, and switch a held-high line from level to edge. In those cases the request must stay set, and later it must clear without re-triggering. A behavioural per-line model judges every cycle of these sequences and of a long random run in which acknowledges, edges and mode writes collide freely.

// File: rtl/irql_pkg.sv
package irql_pkg;

    // bit 1: request pending, bit 0: last sampled level
    typedef enum logic [1:0] {
        LS_QUIET     = 2'b00,
        LS_ARMED     = 2'b01,
        LS_PEND_LOW  = 2'b10,
        LS_PEND_HIGH = 2'b11
    } line_state_e;

endpackage

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
    parameter int                     NUM_LINES     = 8,
    parameter logic [NUM_LINES-1:0]   LEVEL_CAPABLE = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] wr_be,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] mode_q
);

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_bit
        if (LEVEL_CAPABLE[gi]) begin : g_capable
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mode_q[gi] <= 1'b0;
                end else if (wr_be[gi]) begin
                    mode_q[gi] <= wr_data[gi];
                end
            end
        end else begin : g_edge_only
            // this line is wired edge-only; its enable and data are ignored
            logic unused_bits;
            assign unused_bits = wr_be[gi] ^ wr_data[gi] ^ clk ^ rst_n;
            assign mode_q[gi]  = 1'b0;
        end
    end

endmodule

// File: rtl/irql_ack_decode.sv
module irql_ack_decode #(
    parameter int NUM_LINES = 8,
    localparam int LINE_IDW = $clog2(NUM_LINES)
) (
    input  logic                 ack_stb,
    input  logic [LINE_IDW-1:0]  ack_line,
    output logic [NUM_LINES-1:0] ack_hit
);

    always_comb begin
        ack_hit = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (ack_stb && (ack_line == LINE_IDW'(k))) begin
                ack_hit[k] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irql_line_cell.sv
module irql_line_cell
    import irql_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic line_in,
    input  logic ack_hit,
    output logic req_o
);

    line_state_e state_q;
    line_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (level_mode) begin
            state_d = line_in ? LS_PEND_HIGH : LS_QUIET;
        end else begin
            unique case (state_q)
                LS_QUIET: begin
                    state_d = line_in ? LS_PEND_HIGH : LS_QUIET;
                end
                LS_ARMED: begin
                    state_d = line_in ? LS_ARMED : LS_QUIET;
                end
                LS_PEND_LOW: begin
                    if (line_in) begin
                        state_d = LS_PEND_HIGH;     // fresh edge beats ack
                    end else begin
                        state_d = ack_hit ? LS_QUIET : LS_PEND_LOW;
                    end
                end
                LS_PEND_HIGH: begin
                    if (line_in) begin
                        state_d = ack_hit ? LS_ARMED : LS_PEND_HIGH;
                    end else begin
                        state_d = ack_hit ? LS_QUIET : LS_PEND_LOW;
                    end
                end
                default: state_d = LS_QUIET;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LS_PEND_LOW, LS_PEND_HIGH: req_o = 1'b1;
            default:                   req_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irql_latch.sv
module irql_latch #(
    parameter int                   NUM_LINES     = 8,
    parameter logic [NUM_LINES-1:0] LEVEL_CAPABLE = 8'hFA,
    localparam int                  LINE_IDW      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] mode_wr_be,
    input  logic [NUM_LINES-1:0] mode_wr_data,
    input  logic                 ack_stb,
    input  logic [LINE_IDW-1:0]  ack_line,
    output logic [NUM_LINES-1:0] req_o,
    output logic [NUM_LINES-1:0] mode_rd
);

    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] ack_hit;

    irql_mode_reg #(
        .NUM_LINES     (NUM_LINES),
        .LEVEL_CAPABLE (LEVEL_CAPABLE)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_be   (mode_wr_be),
        .wr_data (mode_wr_data),
        .mode_q  (mode_q)
    );

    irql_ack_decode #(
        .NUM_LINES (NUM_LINES)
    ) u_ack (
        .ack_stb  (ack_stb),
        .ack_line (ack_line),
        .ack_hit  (ack_hit)
    );

    for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_line
        irql_line_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_mode (mode_q[gl]),
            .line_in    (irq_in[gl]),
            .ack_hit    (ack_hit[gl]),
            .req_o      (req_o[gl])
        );
    end

    assign mode_rd = mode_q;

endmodule

// File: rtl/irql_latch_chk.sv
module irql_latch_chk #(
    parameter int                   NUM_LINES     = 8,
    parameter logic [NUM_LINES-1:0] LEVEL_CAPABLE = 8'hFA,
    localparam int                  LINE_IDW      = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [NUM_LINES-1:0] mode_wr_be,
    input logic [NUM_LINES-1:0] mode_wr_data,
    input logic                 ack_stb,
    input logic [LINE_IDW-1:0]  ack_line,
    input logic [NUM_LINES-1:0] req_o,
    input logic [NUM_LINES-1:0] mode_rd
);

    logic unused_data;
    assign unused_data = ^mode_wr_data;

    // R2: non-capable lines never read back as level
    a_r2_mode_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd & ~LEVEL_CAPABLE) == '0);

    // R2: no enable, no change
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_be == '0) |=> $stable(mode_rd));

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_chk
        logic hit;
        assign hit = ack_stb && (ack_line == LINE_IDW'(gi));

        // R3, R4: level lines mirror the sampled input
        a_r3_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
            mode_rd[gi] |=> (req_o[gi] == $past(irq_in[gi])));

        // R5: a rise on an edge line sets the request
        a_r5_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_rd[gi] && irq_in[gi] && !$past(irq_in[gi])) |=> req_o[gi]);

        // R6: without an acknowledge an edge request holds
        a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_rd[gi] && req_o[gi] && !hit) |=> req_o[gi]);

        // R7: acknowledge with input low clears an edge request
        a_r7_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_rd[gi] && hit && !irq_in[gi]) |=> !req_o[gi]);

        // R8: fresh edge in the acknowledge cycle wins
        a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_rd[gi] && hit && irq_in[gi] && !$past(irq_in[gi])) |=> req_o[gi]);
    end

endmodule

bind irql_latch irql_latch_chk #(
    .NUM_LINES     (NUM_LINES),
    .LEVEL_CAPABLE (LEVEL_CAPABLE)
) u_irql_latch_chk (.*);

// File: tb/test_irql_latch.sv
module test_irql_latch;

    localparam int NL  = 8;
    localparam logic [NL-1:0] CAP = 8'hFA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic [NL-1:0] mode_wr_be = '0;
    logic [NL-1:0] mode_wr_data = '0;
    logic          ack_stb = 1'b0;
    logic [2:0]    ack_line = '0;
    logic [NL-1:0] req_o;
    logic [NL-1:0] mode_rd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural reference
    bit m_req  [NL];
    bit m_last [NL];
    bit m_mode [NL];

    always #2 clk = ~clk;

    irql_latch #(.NUM_LINES(NL), .LEVEL_CAPABLE(CAP)) i_irql_latch (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .mode_wr_be(mode_wr_be), .mode_wr_data(mode_wr_data),
        .ack_stb(ack_stb), .ack_line(ack_line),
        .req_o(req_o), .mode_rd(mode_rd)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_req[i]) begin
                m_req[i] = 0; m_last[i] = 0; m_mode[i] = 0;
            end
        end else begin
            foreach (m_req[i]) begin
                if (m_mode[i]) begin
                    m_req[i] = irq_in[i];
                end else if (irq_in[i] && !m_last[i]) begin
                    m_req[i] = 1;
                end else if (ack_stb && int'(ack_line) == i) begin
                    m_req[i] = 0;
                end
                m_last[i] = irq_in[i];
            end
            foreach (m_mode[i]) begin
                if (mode_wr_be[i]) m_mode[i] = mode_wr_data[i] & CAP[i];
            end
        end
    end

    function automatic logic [NL-1:0] pack_req();
        logic [NL-1:0] v;
        foreach (m_req[i]) v[i] = m_req[i];
        return v;
    endfunction

    function automatic logic [NL-1:0] pack_mode();
        logic [NL-1:0] v;
        foreach (m_mode[i]) v[i] = m_mode[i];
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R2 R3 R5 R6 R7 R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 R5 R7 model req", 32'(req_o), 32'(pack_req()));
            check("R2 model mode", 32'(mode_rd), 32'(pack_mode()));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        irq_in = 8'h01;            // line 0 high through reset
        repeat (3) tick();
        check("R1 reset req", 32'(req_o), 32'h0);
        check("R1 reset mode", 32'(mode_rd), 32'h0);
        rst_n = 1'b1;
        tick();                    // line 0 counted as a rise
        check("R5 rise after reset", 32'(req_o[0]), 32'h1);
        ack_stb = 1; ack_line = 3'd0; irq_in = '0;
        tick();
        ack_stb = 0;
        check("R7 ack clears line0", 32'(req_o[0]), 32'h0);

        // R2
        mode_wr_be = 8'hFF; mode_wr_data = 8'hFF;
        tick();
        check("R2 masked write", 32'(mode_rd), 32'hFA);
        mode_wr_be = 8'h0F; mode_wr_data = 8'h00;
        tick();
        mode_wr_be = '0;
        check("R2 partial write", 32'(mode_rd), 32'hF0);

        // R3 level line 4
        irq_in = 8'h10; tick();
        check("R3 level set", 32'(req_o[4]), 32'h1);
        irq_in = 8'h00; tick();
        check("R3 level clear", 32'(req_o[4]), 32'h0);

        // R4 ack ignored on level line 5
        irq_in = 8'h20; tick();
        ack_stb = 1; ack_line = 3'd5; tick();
        ack_stb = 0;
        check("R4 level ack ignored", 32'(req_o[5]), 32'h1);
        irq_in = 8'h00; tick();

        // R5 R6 R7 edge lines 0 and 1
        irq_in = 8'h03; tick();
        check("R5 edge set", 32'(req_o[1:0]), 32'h3);
        irq_in = 8'h00; tick();
        check("R6 held after fall", 32'(req_o[1:0]), 32'h3);
        ack_stb = 1; ack_line = 3'd0; tick();
        ack_stb = 0;
        check("R7 only addressed cleared", 32'(req_o[1:0]), 32'h2);
        ack_stb = 1; ack_line = 3'd1; tick();
        ack_stb = 0;

        // R6 no re-trigger on held high, line 2
        irq_in = 8'h04; tick();
        ack_stb = 1; ack_line = 3'd2; tick();
        ack_stb = 0;
        check("R7 ack while high", 32'(req_o[2]), 32'h0);
        tick();
        check("R6 held high no reset", 32'(req_o[2]), 32'h0);
        irq_in = 8'h00; tick();

        // R8 ack coincides with new edge, line 3
        irq_in = 8'h08; tick();
        irq_in = 8'h00; tick();
        check("R8 pending before", 32'(req_o[3]), 32'h1);
        irq_in = 8'h08; ack_stb = 1; ack_line = 3'd3; tick();
        ack_stb = 0;
        check("R8 edge wins", 32'(req_o[3]), 32'h1);
        irq_in = 8'h00;
        ack_stb = 1; tick();
        ack_stb = 0;

        // R9 level to edge while held high, line 6
        irq_in = 8'h40; tick();
        check("R9 level high", 32'(req_o[6]), 32'h1);
        mode_wr_be = 8'h40; mode_wr_data = 8'h00; tick();
        mode_wr_be = '0;
        check("R9 mode switched", 32'(mode_rd[6]), 32'h0);
        check("R9 request kept", 32'(req_o[6]), 32'h1);
        ack_stb = 1; ack_line = 3'd6; tick();
        ack_stb = 0;
        check("R9 ack clears", 32'(req_o[6]), 32'h0);
        tick();
        check("R9 no retrigger", 32'(req_o[6]), 32'h0);
        irq_in = 8'h00; tick();
        irq_in = 8'h40; tick();
        check("R9 fresh edge", 32'(req_o[6]), 32'h1);

        // random collisions, judged by the model every cycle
        for (int c = 0; c < 2000; c++) begin
            irq_in   = 8'($urandom);
            ack_stb  = 1'($urandom);
            ack_line = 3'($urandom);
            if (($urandom % 8) == 0) begin
                mode_wr_be   = 8'($urandom);
                mode_wr_data = 8'($urandom);
            end else begin
                mode_wr_be = '0;
            end
            tick();
        end
        ack_stb = 0; mode_wr_be = '0;
        tick();
        finish_run();
    end

endmodule